// File: doc/BRIEF.md
# Operand-Stack Processor Core

This block is a minimal processor with no general registers. Every computation happens on a small internal last-in-first-out operand stack. Instructions are fetched a byte at a time from a byte-addressed memory, starting at address zero after reset. An opcode is always one byte. Instructions that name a memory location carry a two-byte address after the opcode.

Data words are 32 bits wide. They are held little-endian across four consecutive bytes and cross the single byte-wide memory port one byte per transfer. A transfer completes in any cycle in which the core requests and the memory signals ready.

The core stops on a halt opcode. It also stops on any fault: an unknown opcode, a stack overflow or a stack underflow. A fault additionally raises a sticky error output.

Top module: `stack_core`

## Requirements
- R1: After reset release, `halted` and `error` are 0 and the core immediately requests a read (`mem_we`=0) at address 0.
- R2: Opcode 0x01 (load to stack) and 0x02 (store from stack) are 3 bytes long: the opcode, then the address low byte, then the high byte. Opcode 0x03 (add) and 0x04 (subtract) are 1 byte long. The next opcode is fetched from the byte that follows.
- R3: Opcode 0x01 reads bytes M, M+1, M+2, M+3 as a little-endian word (byte M is bits 7:0) and places it on top of the stack.
- R4: Opcode 0x02 writes the top of stack to M..M+3, least significant byte at M, and removes it from the stack.
- R5: Opcode 0x03 replaces the two top entries with their sum modulo 2^32. It performs no memory write.
- R6: Opcode 0x04 takes X as the entry below the top and Y as the top, and leaves X−Y modulo 2^32. It consumes both X and Y.
- R7: A transfer happens only in a cycle with `mem_req` and `mem_ready` both high. While `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold.
- R8: Opcode 0xFF sets `halted`, leaves `error` at 0, and no request is made afterwards until reset.
- R9: Any opcode other than 0x01–0x04 and 0xFF sets `halted` and a sticky `error`.
- R10: A load-to-stack while 16 entries are held sets `error` and `halted` before any byte of its address or data is read.
- R11: A store-from-stack on an empty stack, or an add/subtract with fewer than two entries, sets `error` and `halted` without any memory write.
- R12: The stack holds 16 entries. Sixteen loads followed by sixteen stores return the words in reverse order, with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid when `mem_ready` is high |
| mem_ready | input | 1 | Memory completes the transfer this cycle |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Sticky fault indication |

## Verification
Single load/store pairs with a distinctive byte pattern show whether byte order and instruction length are handled correctly. An add whose operands overflow the 32-bit range, and a subtract whose operands are pushed small-then-large, separate correct wrap-around and operand order from swapped or truncated arithmetic. A three-statement expression program is run with a memory that stalls every other cycle, to show that waits change neither the result nor the request.

Overflow, underflow and an unknown opcode are each triggered at the exact stack depth that matters. The bench counts transfers to prove that nothing further reaches memory once the core stops. A full-depth fill-and-drain shows that the sixteenth entry is usable and that the order is last-in-first-out.

// File: rtl/stack_core_pkg.sv
package stack_core_pkg;

  localparam logic [7:0] OPC_LOAD  = 8'h01;
  localparam logic [7:0] OPC_STORE = 8'h02;
  localparam logic [7:0] OPC_ADD   = 8'h03;
  localparam logic [7:0] OPC_SUB   = 8'h04;
  localparam logic [7:0] OPC_STOP  = 8'hFF;

  typedef enum logic [2:0] {
    ST_OPC  = 3'd0,
    ST_DEC  = 3'd1,
    ST_ALO  = 3'd2,
    ST_AHI  = 3'd3,
    ST_RD   = 3'd4,
    ST_WR   = 3'd5,
    ST_STOP = 3'd6
  } core_state_e;

endpackage

// File: rtl/stack_core_lifo.sv
module stack_core_lifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic              pop_en,
  input  logic              fold_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] top,
  output logic [DATA_W-1:0] second,
  output logic [CNT_W-1:0]  count
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] ent_q [DEPTH];
  logic [CNT_W-1:0]  count_q, count_d;
  logic [IDX_W-1:0]  top_idx, sec_idx, wr_idx;
  logic              wr_en;

  assign top_idx = IDX_W'(count_q - CNT_W'(1));
  assign sec_idx = IDX_W'(count_q - CNT_W'(2));
  assign wr_idx  = fold_en ? sec_idx : IDX_W'(count_q);
  assign wr_en   = push_en | fold_en;

  always_comb begin
    count_d = count_q;
    if (push_en)               count_d = count_q + CNT_W'(1);
    else if (pop_en | fold_en) count_d = count_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ent_q[wr_idx] <= wdata;
  end

  assign top    = ent_q[top_idx];
  assign second = ent_q[sec_idx];
  assign count  = count_q;

endmodule

// File: rtl/stack_core_alu.sv
module stack_core_alu #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic              sub,
  output logic [DATA_W-1:0] res
);

  assign res = sub ? (lhs - rhs) : (lhs + rhs);

endmodule

// File: rtl/stack_core_ctrl.sv
module stack_core_ctrl
  import stack_core_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready,
  input  logic [CNT_W-1:0]  stk_count,
  input  logic [DATA_W-1:0] stk_top,
  input  logic [DATA_W-1:0] alu_res,
  output logic              stk_push,
  output logic              stk_pop,
  output logic              stk_fold,
  output logic [DATA_W-1:0] stk_wdata,
  output logic              alu_sub,
  output logic              halted,
  output logic              error
);

  localparam int NBYTES = DATA_W / 8;
  localparam int BI_W   = $clog2(NBYTES);
  localparam int HI_W   = ADDR_W - 8;

  core_state_e       state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] maddr_q, maddr_d;
  logic [7:0]        opc_q, opc_d;
  logic [BI_W-1:0]   bidx_q, bidx_d;
  logic [DATA_W-1:0] asm_q, asm_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] asm_shift;
  logic [DATA_W-1:0] top_shift;
  logic              last_byte;
  logic              xfer;

  assign asm_shift = {mem_rdata, asm_q[DATA_W-1:8]};
  assign top_shift = stk_top >> {bidx_q, 3'b000};
  assign last_byte = (bidx_q == BI_W'(NBYTES - 1));
  assign xfer      = mem_req & mem_ready;

  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    maddr_d  = maddr_q;
    opc_d    = opc_q;
    bidx_d   = bidx_q;
    asm_d    = asm_q;
    err_d    = err_q;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = pc_q;
    stk_push = 1'b0;
    stk_pop  = 1'b0;
    stk_fold = 1'b0;
    case (state_q)
      ST_OPC: begin
        mem_req = 1'b1;
        if (xfer) begin
          opc_d   = mem_rdata;
          pc_d    = pc_q + ADDR_W'(1);
          state_d = ST_DEC;
        end
      end
      ST_DEC: begin
        case (opc_q)
          OPC_LOAD: begin
            if (stk_count == CNT_W'(DEPTH)) begin
              err_d   = 1'b1;
              state_d = ST_STOP;
            end else begin
              state_d = ST_ALO;
            end
          end
          OPC_STORE: begin
            if (stk_count == '0) begin
              err_d   = 1'b1;
              state_d = ST_STOP;
            end else begin
              state_d = ST_ALO;
            end
          end
          OPC_ADD, OPC_SUB: begin
            if (stk_count < CNT_W'(2)) begin
              err_d   = 1'b1;
              state_d = ST_STOP;
            end else begin
              stk_fold = 1'b1;
              state_d  = ST_OPC;
            end
          end
          OPC_STOP: state_d = ST_STOP;
          default: begin
            err_d   = 1'b1;
            state_d = ST_STOP;
          end
        endcase
      end
      ST_ALO: begin
        mem_req = 1'b1;
        if (xfer) begin
          maddr_d[7:0] = mem_rdata;
          pc_d         = pc_q + ADDR_W'(1);
          state_d      = ST_AHI;
        end
      end
      ST_AHI: begin
        mem_req = 1'b1;
        if (xfer) begin
          maddr_d[ADDR_W-1:8] = mem_rdata[HI_W-1:0];
          pc_d    = pc_q + ADDR_W'(1);
          bidx_d  = '0;
          state_d = (opc_q == OPC_LOAD) ? ST_RD : ST_WR;
        end
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = maddr_q + ADDR_W'(bidx_q);
        if (xfer) begin
          asm_d  = asm_shift;
          bidx_d = bidx_q + BI_W'(1);
          if (last_byte) begin
            stk_push = 1'b1;
            state_d  = ST_OPC;
          end
        end
      end
      ST_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = maddr_q + ADDR_W'(bidx_q);
        if (xfer) begin
          bidx_d = bidx_q + BI_W'(1);
          if (last_byte) begin
            stk_pop = 1'b1;
            state_d = ST_OPC;
          end
        end
      end
      default: state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPC;
      pc_q    <= '0;
      maddr_q <= '0;
      opc_q   <= '0;
      bidx_q  <= '0;
      asm_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      maddr_q <= maddr_d;
      opc_q   <= opc_d;
      bidx_q  <= bidx_d;
      asm_q   <= asm_d;
      err_q   <= err_d;
    end
  end

  assign mem_wdata = top_shift[7:0];
  assign stk_wdata = (state_q == ST_RD) ? asm_shift : alu_res;
  assign alu_sub   = (opc_q == OPC_SUB);
  assign halted    = (state_q == ST_STOP);
  assign error     = err_q;

endmodule

// File: rtl/stack_core.sv
module stack_core #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready,
  output logic              halted,
  output logic              error
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  stk_count;
  logic [DATA_W-1:0] stk_top, stk_second, stk_wdata, alu_res;
  logic              stk_push, stk_pop, stk_fold, alu_sub;

  stack_core_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready),
    .stk_count (stk_count),
    .stk_top   (stk_top),
    .alu_res   (alu_res),
    .stk_push  (stk_push),
    .stk_pop   (stk_pop),
    .stk_fold  (stk_fold),
    .stk_wdata (stk_wdata),
    .alu_sub   (alu_sub),
    .halted    (halted),
    .error     (error)
  );

  stack_core_lifo #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_lifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_en (stk_push),
    .pop_en  (stk_pop),
    .fold_en (stk_fold),
    .wdata   (stk_wdata),
    .top     (stk_top),
    .second  (stk_second),
    .count   (stk_count)
  );

  stack_core_alu #(.DATA_W(DATA_W)) u_alu (
    .lhs (stk_second),
    .rhs (stk_top),
    .sub (alu_sub),
    .res (alu_res)
  );

endmodule

// File: rtl/stack_core_chk.sv
module stack_core_chk #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ready,
  input logic              halted,
  input logic              error,
  input logic [CNT_W-1:0]  stk_count
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R7
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_ready |=> $stable(mem_wdata)); // R7
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req); // R8
  AST_HALT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R8
  AST_ERR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error); // R9
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> halted); // R9
  AST_DEPTH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    stk_count <= CNT_W'(DEPTH)); // R10

endmodule

bind stack_core stack_core_chk #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .halted    (halted),
  .error     (error),
  .stk_count (stk_count)
);

// File: tb/stack_core_test.sv
module stack_core_test;

  logic        clk;
  logic        rst_n;
  logic        mem_req, mem_we, mem_ready;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        halted, error;

  logic [7:0]  mem [1024];
  logic        ready_gate;
  logic        wait_mode;
  int          rd_xfers, wr_xfers;
  int          n_cmp, n_bad;
  int          pc_w;

  stack_core uut (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .halted(halted), .error(error)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:0]];
  assign mem_ready = mem_req & ready_gate;

  always @(negedge clk) ready_gate <= wait_mode ? ~ready_gate : 1'b1;

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[9:0]] <= mem_wdata;
        wr_xfers <= wr_xfers + 1;
      end else begin
        rd_xfers <= rd_xfers + 1;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    pc_w = 0;
  endtask

  task automatic put_word(int a, logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + i] = v[8*i +: 8];
  endtask

  function automatic logic [31:0] get_word(int a);
    return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
  endfunction

  task automatic emit1(logic [7:0] b);
    mem[pc_w] = b;
    pc_w++;
  endtask

  task automatic emit3(logic [7:0] op, int m);
    emit1(op);
    emit1(m[7:0]);
    emit1(m[15:8]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic run(output int rd, output int wr);
    int rd0, wr0;
    do_reset();
    rd0 = rd_xfers;
    wr0 = wr_xfers;
    for (int c = 0; c < 4000 && !halted; c++) @(negedge clk);
    rd = rd_xfers - rd0;
    wr = wr_xfers - wr0;
  endtask

  task automatic t_reset();
    clear_mem();
    emit1(8'hFF);
    do_reset();
    check("R1 req", {31'd0, mem_req}, 32'd1);
    check("R1 we", {31'd0, mem_we}, 32'd0);
    check("R1 addr", {16'd0, mem_addr}, 32'd0);
    check("R1 halted", {31'd0, halted}, 32'd0);
    check("R1 error", {31'd0, error}, 32'd0);
  endtask

  task automatic t_load_store();
    int rd, wr;
    clear_mem();
    put_word(16'h100, 32'h1234_5678);
    emit3(8'h01, 16'h100);
    emit3(8'h02, 16'h200);
    emit1(8'hFF);
    run(rd, wr);
    check("R3 R4 word copy", get_word(16'h200), 32'h1234_5678);
    check("R4 low byte at M", {24'd0, mem[16'h200]}, 32'h78);
    check("R2 reads", rd, 11);
    check("R4 writes", wr, 4);
    check("R8 halted", {31'd0, halted}, 32'd1);
    check("R8 no error", {31'd0, error}, 32'd0);
    begin
      logic any_req;
      any_req = 1'b0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        any_req |= mem_req;
      end
      check("R8 quiet", {31'd0, any_req}, 32'd0);
    end
  endtask

  task automatic t_add();
    int rd, wr;
    clear_mem();
    put_word(16'h100, 32'hFFFF_FFF0);
    put_word(16'h104, 32'h0000_0025);
    emit3(8'h01, 16'h100);
    emit3(8'h01, 16'h104);
    emit1(8'h03);
    emit3(8'h02, 16'h200);
    emit1(8'hFF);
    run(rd, wr);
    check("R5 sum wrap", get_word(16'h200), 32'h0000_0015);
    check("R5 writes", wr, 4);
    check("R5 operand kept", get_word(16'h100), 32'hFFFF_FFF0);
  endtask

  task automatic t_sub();
    int rd, wr;
    clear_mem();
    put_word(16'h100, 32'h0000_0010);
    put_word(16'h104, 32'h0000_0030);
    emit3(8'h01, 16'h100);
    emit3(8'h01, 16'h104);
    emit1(8'h04);
    emit3(8'h02, 16'h200);
    emit1(8'hFF);
    run(rd, wr);
    check("R6 order", get_word(16'h200), 32'hFFFF_FFE0);
    check("R6 no error", {31'd0, error}, 32'd0);
  endtask

  task automatic t_expr_wait();
    int rd, wr;
    clear_mem();
    wait_mode = 1'b1;
    put_word(16'h104, 32'd7);
    put_word(16'h108, 32'd5);
    emit3(8'h01, 16'h104); emit3(8'h01, 16'h108); emit1(8'h03); emit3(8'h02, 16'h100);
    emit3(8'h01, 16'h100); emit3(8'h01, 16'h108); emit1(8'h03); emit3(8'h02, 16'h104);
    emit3(8'h01, 16'h100); emit3(8'h01, 16'h104); emit1(8'h04); emit3(8'h02, 16'h10C);
    emit1(8'hFF);
    run(rd, wr);
    wait_mode = 1'b0;
    check("R7 first", get_word(16'h100), 32'd12);
    check("R7 second", get_word(16'h104), 32'd17);
    check("R7 diff", get_word(16'h10C), 32'hFFFF_FFFB);
    check("R7 untouched", get_word(16'h108), 32'd5);
    check("R7 writes", wr, 12);
  endtask

  task automatic t_illegal();
    int rd, wr;
    clear_mem();
    emit1(8'h07);
    run(rd, wr);
    check("R9 halted", {31'd0, halted}, 32'd1);
    check("R9 error", {31'd0, error}, 32'd1);
    check("R9 reads", rd, 1);
  endtask

  task automatic t_overflow();
    int rd, wr;
    clear_mem();
    for (int i = 0; i < 17; i++) begin
      put_word(16'h100 + 4*i, 32'hA000_0000 + i);
      emit3(8'h01, 16'h100 + 4*i);
    end
    emit1(8'hFF);
    run(rd, wr);
    check("R10 error", {31'd0, error}, 32'd1);
    check("R10 reads", rd, 113);
  endtask

  task automatic t_depth();
    int rd, wr;
    logic [31:0] got;
    clear_mem();
    for (int i = 0; i < 16; i++) begin
      put_word(16'h100 + 4*i, 32'h5A00_0100 + 32'(i * 3));
      emit3(8'h01, 16'h100 + 4*i);
    end
    for (int j = 0; j < 16; j++) emit3(8'h02, 16'h200 + 4*j);
    emit1(8'hFF);
    run(rd, wr);
    check("R12 no error", {31'd0, error}, 32'd0);
    for (int j = 0; j < 16; j++) begin
      got = get_word(16'h200 + 4*j);
      check("R12 lifo", got, 32'h5A00_0100 + 32'((15 - j) * 3));
    end
  endtask

  task automatic t_underflow();
    int rd, wr;
    clear_mem();
    emit3(8'h02, 16'h200);
    run(rd, wr);
    check("R11 empty store error", {31'd0, error}, 32'd1);
    check("R11 empty store writes", wr, 0);
    clear_mem();
    put_word(16'h100, 32'h0000_0009);
    emit3(8'h01, 16'h100);
    emit1(8'h03);
    emit3(8'h02, 16'h200);
    run(rd, wr);
    check("R11 short add error", {31'd0, error}, 32'd1);
    check("R11 short add writes", wr, 0);
    check("R11 short add reads", rd, 8);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    rd_xfers = 0;
    wr_xfers = 0;
    wait_mode = 1'b0;
    ready_gate = 1'b1;
    rst_n = 1'b0;
    t_reset();
    t_load_store();
    t_add();
    t_sub();
    t_expr_wait();
    t_illegal();
    t_overflow();
    t_depth();
    t_underflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule